// File: doc/BRIEF.md
# Periodic Countdown Interrupt Timer

This block is a 12-bit down-counter that raises an interrupt at a fixed rate. Software sets a preset, picks one of four tick sources and sets the run bit. On each tick from the chosen source the counter steps down by one. When it moves from one to zero, the block sets a sticky status flag. If the interrupt enable is set, it also pulls an open-drain interrupt line low for a fixed time. On the next selected tick the counter reloads the preset and starts the next period.

The tick inputs are single-cycle pulses from the oscillator divider and from the calendar logic. These sources sit outside the block. Because the second and minute ticks are the calendar's own update strobes, a period counted in seconds or minutes starts and ends exactly on a calendar update.

The preset arrives split over a low byte and a high nibble. The flag is cleared by a one-cycle `flag_clr_i` strobe, which stands for software writing zero to the flag. The interrupt output is the enable of the open-drain pull-down: 1 means the line is driven low, 0 means it is released.

Top module: `fixed_cycle_timer`

Count state machine: `CNT_IDLE` (stopped, count follows the preset), `CNT_RUN` (counting down), `CNT_ZERO` (count is zero, waiting to reload).
- IDLE to RUN happens when run is set.
- RUN to ZERO happens on a selected tick with count 1.
- ZERO to RUN happens on the next selected tick, which reloads the preset.
- RUN or ZERO goes to IDLE when run is cleared.

Pulse state machine: `PLS_OFF` (line released) and `PLS_LOW` (line driven low).
- OFF to LOW happens on an event while the interrupt enable is set.
- LOW to OFF happens after the last pulse tick.
- LOW to LOW (restart) happens on a new enabled event.

## Requirements
- R1: After reset the flag is 0 and the interrupt line is released (`irq_pull_low_o` = 0).
- R2: While `run_i` is 0, the count equals the preset one cycle later and ticks do not change it.
- R3: `src_sel_i` picks the decrement tick: 00 = 4096 Hz, 01 = 64 Hz, 10 = seconds, 11 = minutes. Ticks from the other three sources are ignored.
- R4: Once running, the count starts from the preset and drops by exactly one per selected tick.
- R5: A selected tick at count 1 makes the count 0 and sets the flag.
- R6: At count 0 the next selected tick reloads the preset, and counting goes on while `run_i` stays 1.
- R7: The flag stays 1 until a `flag_clr_i` strobe. An event in the same cycle as the strobe leaves the flag at 1.
- R8: The interrupt line is pulled low on an event only if `irq_en_i` is 1.
- R9: The pulse lasts PULSE_TICKS 4096 Hz ticks (32, about 7.8 ms) and is then released. Clearing the flag does not shorten it.
- R10: The preset covers the full 12-bit range up to 4095, counting down from 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_4k_i | input | 1 | 4096 Hz tick, one cycle wide |
| tick_64_i | input | 1 | 64 Hz tick, one cycle wide |
| tick_sec_i | input | 1 | Seconds update strobe |
| tick_min_i | input | 1 | Minutes update strobe |
| preset_lo_i | input | 8 | Preset bits 7:0 |
| preset_hi_i | input | 4 | Preset bits 11:8 |
| src_sel_i | input | 2 | Tick source select |
| run_i | input | 1 | Run enable |
| irq_en_i | input | 1 | Interrupt pulse enable |
| flag_clr_i | input | 1 | Flag clear strobe (software writes 0) |
| count_o | output | 12 | Current count |
| flag_o | output | 1 | Sticky event flag |
| irq_pull_low_o | output | 1 | 1 drives the open-drain interrupt line low |

## Verification
The hardest situation to reach is an event that lands in the same cycle as a flag clear, while an earlier interrupt pulse is still partway through its 32 ticks. The bench uses preset 1 on the seconds source so that events come every other second tick. It then interleaves single 4096 Hz ticks, clear strobes and second ticks at chosen negative edges. This lets it check the pulse length, the priority of the event over the clear, and the reload in one sequence.

// File: rtl/fct_pkg.sv
package fct_pkg;
    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_ZERO = 2'd2
    } cnt_state_e;

    typedef enum logic {
        PLS_OFF = 1'b0,
        PLS_LOW = 1'b1
    } pls_state_e;

    localparam logic [1:0] SRC_4K  = 2'b00;
    localparam logic [1:0] SRC_64  = 2'b01;
    localparam logic [1:0] SRC_SEC = 2'b10;
    localparam logic [1:0] SRC_MIN = 2'b11;
endpackage

// File: rtl/fct_src_mux.sv
module fct_src_mux
    import fct_pkg::*;
(
    input  logic [1:0] sel_i,
    input  logic       t4k_i,
    input  logic       t64_i,
    input  logic       tsec_i,
    input  logic       tmin_i,
    output logic       tick_o
);
    always_comb begin
        unique case (sel_i)
            SRC_4K:  tick_o = t4k_i;
            SRC_64:  tick_o = t64_i;
            SRC_SEC: tick_o = tsec_i;
            SRC_MIN: tick_o = tmin_i;
            default: tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fct_count_fsm.sv
module fct_count_fsm
    import fct_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] preset_i,
    output logic [CNT_W-1:0] count_o,
    output logic             event_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CNT_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_IDLE: if (run_i) state_d = CNT_RUN;
            CNT_RUN: begin
                if (!run_i)                        state_d = CNT_IDLE;
                else if (tick_i && count_o == ONE) state_d = CNT_ZERO;
            end
            CNT_ZERO: begin
                if (!run_i)       state_d = CNT_IDLE;
                else if (tick_i)  state_d = CNT_RUN;
            end
            default: state_d = CNT_IDLE;
        endcase
    end

    assign event_o = (state_q == CNT_RUN) && run_i && tick_i && (count_o == ONE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_o <= '0;
        end else if (!run_i || state_q == CNT_IDLE) begin
            count_o <= preset_i;
        end else if (tick_i) begin
            unique case (state_q)
                CNT_RUN:  count_o <= count_o - ONE;
                CNT_ZERO: count_o <= preset_i;
                default:  count_o <= preset_i;
            endcase
        end
    end
endmodule

// File: rtl/fct_pulse_fsm.sv
module fct_pulse_fsm
    import fct_pkg::*;
#(
    parameter int PULSE_TICKS = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    input  logic t4k_i,
    output logic pull_low_o
);
    localparam int PW = $clog2(PULSE_TICKS + 1);
    localparam logic [PW-1:0] LAST = PW'(PULSE_TICKS - 1);

    pls_state_e state_q, state_d;
    logic [PW-1:0] ticks_q;
    logic          last_tick;

    assign last_tick = t4k_i && (ticks_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= PLS_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PLS_OFF: if (fire_i) state_d = PLS_LOW;
            PLS_LOW: if (!fire_i && last_tick) state_d = PLS_OFF;
            default: state_d = PLS_OFF;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             ticks_q <= '0;
        else if (fire_i)                         ticks_q <= '0;
        else if (state_q == PLS_LOW && t4k_i)    ticks_q <= last_tick ? '0 : ticks_q + 1'b1;
    end

    assign pull_low_o = (state_q == PLS_LOW);
endmodule

// File: rtl/fixed_cycle_timer.sv
module fixed_cycle_timer
    import fct_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int LO_W        = 8,
    parameter int PULSE_TICKS = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_4k_i,
    input  logic             tick_64_i,
    input  logic             tick_sec_i,
    input  logic             tick_min_i,
    input  logic [LO_W-1:0]  preset_lo_i,
    input  logic [CNT_W-LO_W-1:0] preset_hi_i,
    input  logic [1:0]       src_sel_i,
    input  logic             run_i,
    input  logic             irq_en_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             irq_pull_low_o
);
    logic src_tick;
    logic event_w;

    fct_src_mux u_mux (
        .sel_i  (src_sel_i),
        .t4k_i  (tick_4k_i),
        .t64_i  (tick_64_i),
        .tsec_i (tick_sec_i),
        .tmin_i (tick_min_i),
        .tick_o (src_tick)
    );

    fct_count_fsm #(.CNT_W(CNT_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_i),
        .tick_i   (src_tick),
        .preset_i ({preset_hi_i, preset_lo_i}),
        .count_o  (count_o),
        .event_o  (event_w)
    );

    fct_pulse_fsm #(.PULSE_TICKS(PULSE_TICKS)) u_pls (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fire_i     (event_w && irq_en_i),
        .t4k_i      (tick_4k_i),
        .pull_low_o (irq_pull_low_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         flag_o <= 1'b0;
        else if (event_w)    flag_o <= 1'b1;
        else if (flag_clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/fct_timer_chk.sv
module fct_timer_chk #(
    parameter int CNT_W = 12,
    parameter int LO_W  = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_4k_i,
    input logic             tick_64_i,
    input logic             tick_sec_i,
    input logic             tick_min_i,
    input logic [LO_W-1:0]  preset_lo_i,
    input logic [CNT_W-LO_W-1:0] preset_hi_i,
    input logic [1:0]       src_sel_i,
    input logic             run_i,
    input logic             irq_en_i,
    input logic             flag_clr_i,
    input logic [CNT_W-1:0] count_o,
    input logic             flag_o,
    input logic             irq_pull_low_o
);
    logic sel_tick;
    assign sel_tick = (src_sel_i == 2'b00 && tick_4k_i) || (src_sel_i == 2'b01 && tick_64_i)
                   || (src_sel_i == 2'b10 && tick_sec_i) || (src_sel_i == 2'b11 && tick_min_i);

    AST_IDLE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> count_o == $past({preset_hi_i, preset_lo_i})); // R2

    AST_ZERO_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && $past(run_i) && sel_tick && count_o == CNT_W'(1)) |=> (flag_o && count_o == '0)); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !flag_clr_i) |=> flag_o); // R7

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_pull_low_o) |-> $past(irq_en_i)); // R8

    AST_PULSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_pull_low_o && !tick_4k_i) |=> irq_pull_low_o); // R9
endmodule

bind fixed_cycle_timer fct_timer_chk #(.CNT_W(CNT_W), .LO_W(LO_W)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_4k_i      (tick_4k_i),
    .tick_64_i      (tick_64_i),
    .tick_sec_i     (tick_sec_i),
    .tick_min_i     (tick_min_i),
    .preset_lo_i    (preset_lo_i),
    .preset_hi_i    (preset_hi_i),
    .src_sel_i      (src_sel_i),
    .run_i          (run_i),
    .irq_en_i       (irq_en_i),
    .flag_clr_i     (flag_clr_i),
    .count_o        (count_o),
    .flag_o         (flag_o),
    .irq_pull_low_o (irq_pull_low_o)
);

// File: tb/fixed_cycle_timer_bench.sv
module fixed_cycle_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        t4k = 0, t64 = 0, tsec = 0, tmin = 0;
    logic [7:0]  p_lo = 8'd3;
    logic [3:0]  p_hi = 4'd0;
    logic [1:0]  sel = 2'b01;
    logic        run = 0, irq_en = 0, fclr = 0;
    logic [11:0] count;
    logic        flag, irq_low;
    int          n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    fixed_cycle_timer u_fixed_cycle_timer (
        .clk_i(clk), .rst_ni(rst_n),
        .tick_4k_i(t4k), .tick_64_i(t64), .tick_sec_i(tsec), .tick_min_i(tmin),
        .preset_lo_i(p_lo), .preset_hi_i(p_hi), .src_sel_i(sel),
        .run_i(run), .irq_en_i(irq_en), .flag_clr_i(fclr),
        .count_o(count), .flag_o(flag), .irq_pull_low_o(irq_low)
    );

    // {tick mask [min,sec,64,4k], expected count, expected flag}; preset 3, 64 Hz source
    localparam logic [16:0] VEC [0:9] = '{
        {4'b0010, 12'd2, 1'b0},
        {4'b0001, 12'd2, 1'b0},
        {4'b0010, 12'd1, 1'b0},
        {4'b1100, 12'd1, 1'b0},
        {4'b0010, 12'd0, 1'b1},
        {4'b0001, 12'd0, 1'b1},
        {4'b0010, 12'd3, 1'b1},
        {4'b0010, 12'd2, 1'b1},
        {4'b0010, 12'd1, 1'b1},
        {4'b0010, 12'd0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] m);
        @(negedge clk);
        {tmin, tsec, t64, t4k} = m;
        @(negedge clk);
        {tmin, tsec, t64, t4k} = 4'b0000;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flag", flag, 0);
        chk("R1 irq", irq_low, 0);
        chk("R2 idle count", count, 3);

        run = 1'b1;
        step(4'b0000);
        for (int i = 0; i < 10; i++) begin
            step(VEC[i][16:13]);
            chk("R3/R4/R5/R6 table count", count, 32'(VEC[i][12:1]));
            chk("R5/R7 table flag", flag, 32'(VEC[i][0]));
        end

        @(negedge clk); fclr = 1'b1;
        @(negedge clk); fclr = 1'b0;
        chk("R7 clear", flag, 0);

        run = 1'b0;
        step(4'b0010);
        chk("R2 stopped", count, 3);
        p_lo = 8'hFF; p_hi = 4'hF;
        step(4'b1111);
        chk("R2 follows preset", count, 4095);

        sel = 2'b11; run = 1'b1;
        step(4'b0000);
        step(4'b0111);
        chk("R3 minute ignores others", count, 4095);
        step(4'b1000);
        chk("R10 max preset decrement", count, 4094);

        run = 1'b0; p_lo = 8'd1; p_hi = 4'd0; sel = 2'b10; irq_en = 1'b1;
        step(4'b0000);
        run = 1'b1;
        step(4'b0000);
        step(4'b0100);
        chk("R5 count zero", count, 0);
        chk("R5 flag set", flag, 1);
        chk("R8 irq low", irq_low, 1);

        @(negedge clk); fclr = 1'b1;
        @(negedge clk); fclr = 1'b0;
        chk("R7 cleared", flag, 0);
        chk("R9 pulse not cut", irq_low, 1);
        repeat (31) step(4'b0001);
        chk("R9 low after 31 ticks", irq_low, 1);
        step(4'b0001);
        chk("R9 released after 32 ticks", irq_low, 0);

        step(4'b0100);
        chk("R6 reload", count, 1);
        step(4'b0100);
        chk("R5 second event", flag, 1);
        step(4'b0100);
        chk("R6 reload again", count, 1);
        @(negedge clk); fclr = 1'b1; tsec = 1'b1;
        @(negedge clk); fclr = 1'b0; tsec = 1'b0;
        chk("R7 event beats clear", flag, 1);

        repeat (33) step(4'b0001);
        chk("R9 pulse expired", irq_low, 0);
        irq_en = 1'b0;
        step(4'b0100);
        step(4'b0100);
        chk("R8 flag without irq", flag, 1);
        chk("R8 no irq when disabled", irq_low, 0);

        finish_run();
    end
endmodule